// File: doc/BRIEF.md
# EPROM Program-Pulse Sequencer

This controller sits on the programmer side of a 16-bit-wide UV-erasable memory and writes an image into it word by word. The image comes from a word source that answers a request/valid handshake. For each address the sequencer fetches the target word and reads the location back. If the location already holds the target, it receives no pulse. If the target needs a bit raised from 0 to 1, the sequencer stops with a hard error, because programming can only clear bits. Otherwise it applies fixed-length program pulses and reads the word back after each one. It moves on once the word matches, and stops with a failure once the pulse budget runs out.

After the last address the sequencer drops both supply-level selects to the nominal level and reads every location again, comparing each against the image. It drives the memory's active-low chip-enable/program and output-enable lines, the address, the data bus and its direction, a high-voltage enable for the programming supply, and a select that raises the core supply. Status is reported as sticky done/fail levels, a 2-bit failure kind and the first failing address. All of these are cleared by the next start.

Top module: `eprom_pulse_seq`

## Requirements
- R1: After reset and whenever idle: `ce_pgm_n`=1, `oe_n`=1, `mem_doe`=0, `vpp_hi`=0, `vcc_hi`=0, `busy`=0. After reset `done` and `fail` are also 0.
- R2: Each program pulse holds `ce_pgm_n` low for exactly PULSE_CYC cycles. During the pulse `oe_n`=1, `mem_doe`=1, `vpp_hi`=1, `vcc_hi`=1, and `mem_dout` carries the image word of the addressed location.
- R3: `oe_n` is low only while `ce_pgm_n` is high and `mem_doe` is low, and `mem_doe` was already low in the cycle before `oe_n` falls.
- R4: Every address is read before any pulse. A matching word gets zero pulses. After each pulse the word is read back, and pulsing at that address stops at the first match.
- R5: If the word still differs after MAX_PULSES pulses, the run stops with `fail`=1, `fail_kind`=2'd1 and `fail_addr` set to that address.
- R6: If the first read shows a 0 where the target word has a 1, the run stops with no pulse at that address, with `fail`=1, `fail_kind`=2'd2 and `fail_addr` set to the address.
- R7: Addresses run upward from 0 to NWORDS-1. `img_req` stays high with a stable `img_addr` until `img_vld`, and `img_data` is taken in the cycle where `img_vld` is high. A successful run makes exactly 2·NWORDS fetches.
- R8: After the last address, `vpp_hi`=0 and `vcc_hi`=0 while every location is read once more and compared. The first mismatch stops the run with `fail_kind`=2'd3 and `fail_addr` set to that address.
- R9: A run that completes sets `done`=1 and `fail`=0. `done` and `fail` are never both high, and `start` is ignored while `busy`.
- R10: `done`, `fail`, `fail_kind` and `fail_addr` hold their values after the run ends, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky: last run completed without error |
| fail | output | 1 | Sticky: last run stopped on an error |
| fail_kind | output | 2 | 1 pulse budget, 2 needs erase, 3 final verify mismatch |
| fail_addr | output | AW | Address where the run stopped |
| img_req | output | 1 | Request for an image word |
| img_addr | output | AW | Address of the requested image word |
| img_vld | input | 1 | Image word present on img_data |
| img_data | input | DW | Image word |
| mem_addr | output | AW | Memory address lines |
| mem_dout | output | DW | Data driven toward the memory |
| mem_doe | output | 1 | 1 = drive the data bus, 0 = release it |
| mem_din | input | DW | Data read from the memory |
| ce_pgm_n | output | 1 | Active-low chip enable / program pulse |
| oe_n | output | 1 | Active-low output enable |
| vpp_hi | output | 1 | Programming supply high-voltage enable |
| vcc_hi | output | 1 | Raised core-supply select |

## Verification
A pulse ends exactly PULSE_CYC cycles after `ce_pgm_n` falls. The read-back word is captured at the edge that closes the one-cycle `oe_n` window, and it is judged one cycle later. A status change therefore reaches the ports one cycle after that judgement, and an image word is consumed at the edge where `img_vld` is high. The bench samples every output on the falling clock edge, half a cycle clear of these updates. It reconstructs pulses from the `ce_pgm_n` rising edge and compares their addresses, in order, with a queue that the driver fills from the image, the memory's initial contents and each location's required pulse count. Status and memory contents are checked only once `done` or `fail` appear.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RLS,
      ST_READ,
      ST_EVAL,
      ST_SETUP,
      ST_PULSE
   } seq_st_t;

   localparam logic [1:0] FK_NONE   = 2'd0;
   localparam logic [1:0] FK_BUDGET = 2'd1;
   localparam logic [1:0] FK_ERASE  = 2'd2;
   localparam logic [1:0] FK_VERIFY = 2'd3;

endpackage

// File: rtl/pps_pulse_timer.sv
module pps_pulse_timer #(
   parameter int unsigned LEN = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   generate
      if (LEN < 1) begin : g_bad_len
         $error("pps_pulse_timer: LEN must be at least 1");
      end

      if (LEN == 1) begin : g_single
         assign last = run;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(LEN);
         logic [CW-1:0] cnt;

         assign last = run && (cnt == CW'(LEN - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || last)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         // R2
         cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CW'(LEN - 1));
      end
   endgenerate

endmodule

// File: rtl/pps_word_check.sv
module pps_word_check #(
   parameter int DW        = 16,
   parameter bit ERASE_CHK = 1'b1
) (
   input  logic [DW-1:0] target,
   input  logic [DW-1:0] rdback,
   output logic          match,
   output logic          erase_need
);

   logic [DW-1:0] diff;

   for (genvar i = 0; i < DW; i++) begin : g_diff
      assign diff[i] = target[i] ^ rdback[i];
   end

   assign match = ~|diff;

   generate
      if (ERASE_CHK) begin : g_chk
         logic [DW-1:0] up;
         for (genvar j = 0; j < DW; j++) begin : g_up
            assign up[j] = target[j] & ~rdback[j];
         end
         assign erase_need = |up;
      end else begin : g_nochk
         assign erase_need = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/eprom_pulse_seq.sv
module eprom_pulse_seq
   import pps_pkg::*;
#(
   parameter int          AW         = 18,
   parameter int          DW         = 16,
   parameter int          NWORDS     = 262144,
   parameter int unsigned PULSE_CYC  = 12500,
   parameter int unsigned MAX_PULSES = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic [1:0]    fail_kind,
   output logic [AW-1:0] fail_addr,
   output logic          img_req,
   output logic [AW-1:0] img_addr,
   input  logic          img_vld,
   input  logic [DW-1:0] img_data,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dout,
   output logic          mem_doe,
   input  logic [DW-1:0] mem_din,
   output logic          ce_pgm_n,
   output logic          oe_n,
   output logic          vpp_hi,
   output logic          vcc_hi
);

   localparam int unsigned PCW       = $clog2(MAX_PULSES + 1);
   localparam logic [AW-1:0] LAST_A  = AW'(NWORDS - 1);
   localparam logic [PCW-1:0] PMAX   = PCW'(MAX_PULSES);

   generate
      if (NWORDS < 1 || NWORDS > (2 ** AW)) begin : g_bad_words
         $error("eprom_pulse_seq: NWORDS must fit in AW address bits");
      end
      if (MAX_PULSES < 1) begin : g_bad_max
         $error("eprom_pulse_seq: MAX_PULSES must be at least 1");
      end
   endgenerate

   seq_st_t        st;
   logic [AW-1:0]  addr;
   logic [PCW-1:0] pcnt;
   logic [DW-1:0]  tgt;
   logic [DW-1:0]  rd_q;
   logic           vphase;
   logic           done_q;
   logic           fail_q;
   logic [1:0]     kind_q;
   logic [AW-1:0]  faddr_q;

   logic           t_last;
   logic           w_match;
   logic           w_erase;

   pps_pulse_timer #(
      .LEN (PULSE_CYC)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == ST_PULSE),
      .last  (t_last)
   );

   pps_word_check #(
      .DW        (DW),
      .ERASE_CHK (1'b1)
   ) u_check (
      .target     (tgt),
      .rdback     (rd_q),
      .match      (w_match),
      .erase_need (w_erase)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr    <= '0;
         pcnt    <= '0;
         tgt     <= '0;
         rd_q    <= '0;
         vphase  <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         kind_q  <= FK_NONE;
         faddr_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  addr    <= '0;
                  pcnt    <= '0;
                  vphase  <= 1'b0;
                  done_q  <= 1'b0;
                  fail_q  <= 1'b0;
                  kind_q  <= FK_NONE;
                  faddr_q <= '0;
                  st      <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (img_vld) begin
                  tgt <= img_data;
                  st  <= ST_RLS;
               end
            end
            ST_RLS: st <= ST_READ;
            ST_READ: begin
               rd_q <= mem_din;
               st   <= ST_EVAL;
            end
            ST_EVAL: begin
               if (w_match) begin
                  pcnt <= '0;
                  if (addr == LAST_A) begin
                     addr <= '0;
                     if (vphase) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                     end else begin
                        vphase <= 1'b1;
                        st     <= ST_FETCH;
                     end
                  end else begin
                     addr <= addr + 1'b1;
                     st   <= ST_FETCH;
                  end
               end else if (vphase) begin
                  fail_q  <= 1'b1;
                  kind_q  <= FK_VERIFY;
                  faddr_q <= addr;
                  st      <= ST_IDLE;
               end else if (pcnt == '0 && w_erase) begin
                  fail_q  <= 1'b1;
                  kind_q  <= FK_ERASE;
                  faddr_q <= addr;
                  st      <= ST_IDLE;
               end else if (pcnt == PMAX) begin
                  fail_q  <= 1'b1;
                  kind_q  <= FK_BUDGET;
                  faddr_q <= addr;
                  st      <= ST_IDLE;
               end else begin
                  st <= ST_SETUP;
               end
            end
            ST_SETUP: st <= ST_PULSE;
            ST_PULSE: begin
               if (t_last) begin
                  pcnt <= pcnt + 1'b1;
                  st   <= ST_RLS;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign done      = done_q;
   assign fail      = fail_q;
   assign fail_kind = kind_q;
   assign fail_addr = faddr_q;

   assign img_req   = (st == ST_FETCH);
   assign img_addr  = addr;

   assign mem_addr  = addr;
   assign mem_dout  = tgt;
   assign mem_doe   = (st == ST_SETUP) || (st == ST_PULSE);
   assign ce_pgm_n  = (st != ST_PULSE);
   assign oe_n      = (st != ST_READ);
   assign vpp_hi    = busy && !vphase;
   assign vcc_hi    = busy && !vphase;

   // R3
   read_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (ce_pgm_n && !mem_doe));

   // R3
   release_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n) |-> !$past(mem_doe));

   // R2
   pgm_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_pgm_n |-> (oe_n && mem_doe && vpp_hi && vcc_hi));

   // R5
   pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= PMAX);

   // R9
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (img_req && !img_vld) |=> (img_req && $stable(img_addr)));

   // R8
   no_pgm_low_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc_hi |-> ce_pgm_n);

   // R10
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(done) && $stable(fail) && $stable(fail_kind)));

endmodule

// File: tb/test_eprom_pulse_seq.sv
module test_eprom_pulse_seq;

   localparam int AW = 3;
   localparam int DW = 16;
   localparam int NW = 8;
   localparam int PC = 6;
   localparam int MP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          busy, done, fail;
   logic [1:0]    fail_kind;
   logic [AW-1:0] fail_addr;
   logic          img_req;
   logic [AW-1:0] img_addr;
   logic          img_vld = 1'b0;
   logic [DW-1:0] img_data = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dout;
   logic          mem_doe;
   logic [DW-1:0] mem_din;
   logic          ce_pgm_n, oe_n, vpp_hi, vcc_hi;

   always #4 clk = ~clk;

   eprom_pulse_seq #(
      .AW(AW), .DW(DW), .NWORDS(NW), .PULSE_CYC(PC), .MAX_PULSES(MP)
   ) i_eprom_pulse_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .fail(fail), .fail_kind(fail_kind), .fail_addr(fail_addr),
      .img_req(img_req), .img_addr(img_addr), .img_vld(img_vld),
      .img_data(img_data), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_doe(mem_doe), .mem_din(mem_din), .ce_pgm_n(ce_pgm_n),
      .oe_n(oe_n), .vpp_hi(vpp_hi), .vcc_hi(vcc_hi)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] mem [NW];
   logic [DW-1:0] img [NW];
   int need [NW];
   int hits [NW];
   int exp_q [$];
   int plen = 0;
   logic prev_ce = 1'b1, prev_oe = 1'b1, prev_doe = 1'b0, prev_vcc = 1'b0;
   logic [DW-1:0] pdata = '0;
   logic [AW-1:0] paddr = '0;
   int fetches = 0;
   int vreads = 0;
   int corrupt_addr = -1;
   int wc = 0;
   int cycles = 0;

   assign mem_din = (!oe_n && ce_pgm_n) ? mem[mem_addr] : 16'h0000;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // image word source: answers two cycles after a request
   always @(negedge clk) begin
      if (img_vld) img_vld <= 1'b0;
      else if (img_req) begin
         if (wc == 1) begin
            img_vld  <= 1'b1;
            img_data <= img[img_addr];
            wc = 0;
            fetches++;
         end else wc = wc + 1;
      end else wc = 0;
   end

   // monitor and memory model
   always @(negedge clk) begin
      if (rst_n) begin
         if (!ce_pgm_n) begin
            plen++;
            pdata = mem_dout;
            paddr = mem_addr;
         end else if (!prev_ce) begin
            // R2 pulse width and data
            check(plen == PC, "R2", "pulse length", plen, PC);
            check(pdata == img[paddr], "R2", "pulse data", pdata, img[paddr]);
            // R4 scoreboard pop
            if (exp_q.size() == 0)
               check(1'b0, "R4", "unexpected pulse at", paddr, 0);
            else begin
               int e;
               e = exp_q.pop_front();
               check(int'(paddr) == e, "R4", "pulse address", paddr, e);
            end
            hits[paddr]++;
            if (hits[paddr] >= need[paddr]) mem[paddr] = mem[paddr] & pdata;
            plen = 0;
         end
         if (!oe_n && prev_oe) begin
            // R3
            check(ce_pgm_n && !mem_doe && !prev_doe, "R3", "read bus state",
                  {ce_pgm_n, mem_doe, prev_doe}, 3'b100);
            if (!vcc_hi && !vpp_hi) vreads++;
         end
         if (prev_vcc && !vcc_hi && busy && corrupt_addr >= 0)
            mem[corrupt_addr][0] = 1'b1;
      end
      prev_ce  = ce_pgm_n;
      prev_oe  = oe_n;
      prev_doe = mem_doe;
      prev_vcc = vcc_hi;
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check_idle(input string req);
      check(ce_pgm_n && oe_n && !mem_doe && !vpp_hi && !vcc_hi && !busy, req,
            "idle pins", {ce_pgm_n, oe_n, mem_doe, vpp_hi, vcc_hi, busy}, 6'b110000);
   endtask

   task automatic run_case(input int cor);
      logic [DW-1:0] m [NW];
      bit ok;
      logic [1:0] ekind;
      int eaddr;
      int w;
      string kreq;
      ok = 1'b1; ekind = 2'd0; eaddr = 0;
      exp_q.delete();
      for (int a = 0; a < NW; a++) begin
         m[a] = mem[a];
         hits[a] = 0;
      end
      for (int a = 0; a < NW; a++) begin
         if (m[a] == img[a]) continue;
         if ((~m[a] & img[a]) != 0) begin
            ok = 1'b0; ekind = 2'd2; eaddr = a; break;
         end
         if (need[a] > MP) begin
            for (int k = 0; k < MP; k++) exp_q.push_back(a);
            ok = 1'b0; ekind = 2'd1; eaddr = a; break;
         end
         for (int k = 0; k < need[a]; k++) exp_q.push_back(a);
      end
      if (ok && cor >= 0) begin
         ok = 1'b0; ekind = 2'd3; eaddr = cor;
      end
      corrupt_addr = cor;
      fetches = 0;
      vreads = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      // R9: a start while busy must change nothing
      repeat (15) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      w = 0;
      while (!(done || fail) && w < 5000) begin
         @(negedge clk);
         w++;
      end
      check(exp_q.size() == 0, "R4", "pulses missing", exp_q.size(), 0);
      if (ok) begin
         check(done && !fail, "R9", "done/fail", {done, fail}, 2'b10);
         check(vreads == NW, "R8", "nominal-rail reads", vreads, NW);
         check(fetches == 2 * NW, "R7", "image fetches", fetches, 2 * NW);
         for (int a = 0; a < NW; a++)
            check(mem[a] == img[a], "R4", "programmed word", mem[a], img[a]);
      end else begin
         kreq = (ekind == 2'd1) ? "R5" : (ekind == 2'd2) ? "R6" : "R8";
         check(fail && !done, kreq, "done/fail", {done, fail}, 2'b01);
         check(fail_kind == ekind, kreq, "fail kind", fail_kind, ekind);
         check(int'(fail_addr) == eaddr, kreq, "fail address", fail_addr, eaddr);
      end
      repeat (5) @(negedge clk);
      // R10 status held
      check(done == ok && fail == !ok && (ok || fail_kind == ekind), "R10",
            "held status", {done, fail, fail_kind}, {ok, !ok, ekind});
      check_idle("R1");
   endtask

   task automatic erase_all();
      for (int a = 0; a < NW; a++) mem[a] = 16'hFFFF;
   endtask

   task automatic base_need();
      need[0] = 1; need[1] = 1; need[2] = MP; need[3] = 2;
      need[4] = 1; need[5] = 1; need[6] = 3;  need[7] = 1;
   endtask

   initial begin
      img[0] = 16'hFFFF; img[1] = 16'h1234; img[2] = 16'hA5A5; img[3] = 16'h0000;
      img[4] = 16'hFFFF; img[5] = 16'h7FFE; img[6] = 16'hC3C3; img[7] = 16'h0F0F;
      erase_all();
      base_need();
      repeat (3) @(negedge clk);
      // R1 reset state
      check_idle("R1");
      check(!done && !fail, "R1", "reset status", {done, fail}, 2'b00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R1");

      // R4 R7 R8 R9: erased part, varied pulse needs incl. exactly MP (boundary)
      run_case(-1);
      // R4: already-matching contents receive no pulses
      run_case(-1);
      // R5: one location needs more than the budget
      erase_all(); base_need(); need[6] = MP + 1;
      run_case(-1);
      // R6: a programmed zero where the image wants a one
      erase_all(); base_need(); mem[3] = 16'h00FF; img[3] = 16'h0FF0;
      run_case(-1);
      img[3] = 16'h0000;
      // R8: location 5 loses a bit before the final pass
      erase_all(); base_need();
      run_case(5);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule